// File: doc/BRIEF.md
# Power-On Strap Latch and Frequency Code Select

This block owns five shared pads that serve as configuration straps while power-on reset is held and as clock outputs afterwards. While reset is low the pads are undriven and read as inputs. On the first rising clock edge after reset releases, their levels are stored in a five-bit strap latch: four frequency-select bits and one mode bit. One cycle later the pad direction enables rise, and from then on the pads carry clocks. The latch is not loaded again until the next reset.

The block then produces the five-bit frequency code for the synthesizer. A source bit in a programmed configuration byte chooses between two sources. When it is clear, the code comes from the strap latch: the four strap bits fill the low bits and the top bit is zero. When it is set, the code comes from configuration byte bits 2 and 7:4. It also returns the inverted latched strap values for register read-back. The latched mode bit decides whether a neighbouring shared pin acts as a reference clock output or as a clock-stop request input.

The sequencer has three states:
- `ST_HOLD`: pads are sampled and the latch follows its reset value.
- `ST_GRAB`: the capture has just happened and the pads are still undriven.
- `ST_DRIVE`: the pads are driven.

Its transitions are:
- HOLD→GRAB on the first edge out of reset.
- GRAB→DRIVE on the next edge.
- DRIVE→DRIVE from then on.
- Any state→HOLD when reset is asserted (asynchronous).

Top module: `strap_freq_select`

## Requirements
- R1: While `rst_n` is low, `pad_oe_o` is 5'b00000, both shared-pin role enables are 0, and the latch holds all ones, the level of an open pad pulled up. So `strap_rb_n_o` reads 5'b00000, and with configuration bit 3 clear `freq_code_o` reads 5'b01111.
- R2: On the first rising edge with `rst_n` high, the latch stores `strap_pad_i`. Bits 3:0 are the frequency-select straps and bit 4 is the mode strap.
- R3: `pad_oe_o` stays 5'b00000 through the capture edge and becomes 5'b11111 on the following edge.
- R4: After capture, changes on `strap_pad_i` have no effect on the latch, the read-back or the frequency code until the next reset.
- R5: With configuration bit 3 at 0, `freq_code_o` equals {1'b0, latched bits 3:0}.
- R6: With configuration bit 3 at 1, `freq_code_o` equals {configuration bit 2, configuration bits 7:4}, whatever the straps were.
- R7: `strap_rb_n_o` is the bitwise inverse of the five latched strap bits.
- R8: Once the pads are driven, a latched mode bit of 1 gives `ref_drive_en_o`=1 and `stop_req_en_o`=0, and a mode bit of 0 gives the opposite. The two are never high together.
- R9: A new reset returns the block to sampling with the enables low. The next release captures the pads afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous assert |
| strap_pad_i | input | 5 | Pad input levels: [3:0] frequency straps, [4] mode strap |
| prog_cfg_i | input | 8 | Programmed configuration byte: [3] source, [2] code bit 4, [7:4] code bits 3:0 |
| pad_oe_o | output | 5 | Output enables of the five shared pads |
| freq_code_o | output | 5 | Selected frequency code |
| strap_rb_n_o | output | 5 | Inverted latched strap values for read-back |
| ref_drive_en_o | output | 1 | Shared pin acts as reference clock output |
| stop_req_en_o | output | 1 | Shared pin acts as clock-stop request input |

## Verification
A sequencer stuck in or skipping the grab state shows up directly on `pad_oe_o`. Either the enables rise on the capture edge itself, or they never rise, and both are visible one cycle after reset release. A latch that keeps loading, or loads the wrong edge, changes the read-back and the frequency code as soon as the pads move after capture. A bench that toggles the pads in the first driven cycle exposes it within one clock. A swapped source select or a non-inverted read-back is wrong on the very first sample after capture.

// File: rtl/strap_pkg.sv
package strap_pkg;
    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_GRAB  = 2'd1,
        ST_DRIVE = 2'd2
    } strap_state_e;
endpackage

// File: rtl/strap_seq_fsm.sv
module strap_seq_fsm
    import strap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    output logic cap_en,
    output logic drive_en
);
    strap_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD:  state_d = ST_GRAB;
            ST_GRAB:  state_d = ST_DRIVE;
            ST_DRIVE: state_d = ST_DRIVE;
            default:  state_d = ST_HOLD;
        endcase
    end

    // outputs
    always_comb begin
        cap_en   = 1'b0;
        drive_en = 1'b0;
        unique case (state_q)
            ST_HOLD:  cap_en   = 1'b1;
            ST_GRAB:  drive_en = 1'b0;
            ST_DRIVE: drive_en = 1'b1;
            default:  cap_en   = 1'b0;
        endcase
    end

    // R3: the cycle after a grab always drives
    p_drive_after_grab_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GRAB) |=> drive_en);
endmodule

// File: rtl/strap_latch.sv
module strap_latch #(
    parameter int N_STRAP = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cap_en,
    input  logic [N_STRAP-1:0] pad_lvl,
    output logic [N_STRAP-1:0] strap_q
);
    for (genvar i = 0; i < N_STRAP; i++) begin : g_cell
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      strap_q[i] <= 1'b1;
            else if (cap_en) strap_q[i] <= pad_lvl[i];
        end
    end

    // R4: latch frozen outside the capture window
    p_latch_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> $stable(strap_q));
endmodule

// File: rtl/freq_src_mux.sv
module freq_src_mux #(
    parameter int FS_W = 4
) (
    input  logic          use_prog,
    input  logic [FS_W-1:0] prog_lo,
    input  logic          prog_hi,
    input  logic [FS_W-1:0] strap_fs,
    output logic [FS_W:0] code
);
    always_comb begin
        if (use_prog) code = {prog_hi, prog_lo};
        else          code = {1'b0, strap_fs};
    end
endmodule

// File: rtl/strap_freq_select.sv
module strap_freq_select #(
    parameter int N_STRAP  = 5,
    parameter int FS_W     = 4,
    parameter int CFG_W    = 8,
    parameter int SRC_BIT  = 3,
    parameter int HI_BIT   = 2,
    parameter int LO_BASE  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_STRAP-1:0] strap_pad_i,
    input  logic [CFG_W-1:0]   prog_cfg_i,
    output logic [N_STRAP-1:0] pad_oe_o,
    output logic [FS_W:0]      freq_code_o,
    output logic [N_STRAP-1:0] strap_rb_n_o,
    output logic               ref_drive_en_o,
    output logic               stop_req_en_o
);
    localparam int MODE_IDX = N_STRAP - 1;

    logic               cap_en;
    logic               drive_en;
    logic [N_STRAP-1:0] strap_q;

    strap_seq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (cap_en),
        .drive_en (drive_en)
    );

    strap_latch #(.N_STRAP(N_STRAP)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_en  (cap_en),
        .pad_lvl (strap_pad_i),
        .strap_q (strap_q)
    );

    freq_src_mux #(.FS_W(FS_W)) u_mux (
        .use_prog (prog_cfg_i[SRC_BIT]),
        .prog_lo  (prog_cfg_i[LO_BASE +: FS_W]),
        .prog_hi  (prog_cfg_i[HI_BIT]),
        .strap_fs (strap_q[FS_W-1:0]),
        .code     (freq_code_o)
    );

    assign pad_oe_o       = {N_STRAP{drive_en}};
    assign strap_rb_n_o   = ~strap_q;
    assign ref_drive_en_o = drive_en &  strap_q[MODE_IDX];
    assign stop_req_en_o  = drive_en & ~strap_q[MODE_IDX];

    // R3: pads undriven while being sampled
    p_no_drive_in_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |-> (pad_oe_o == '0));

    // R8: shared pin has one role at most
    p_role_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ref_drive_en_o, stop_req_en_o}));

    // R7: read-back holds after capture
    p_rb_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> $stable(strap_rb_n_o));

    // R5: strap-sourced code holds once captured
    p_code_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!prog_cfg_i[SRC_BIT] && $past(!prog_cfg_i[SRC_BIT]) && !cap_en && $past(!cap_en))
        |-> $stable(freq_code_o));
endmodule

// File: tb/strap_freq_select_test.sv
module strap_freq_select_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] strap_pad_i = 5'h1f;
    logic [7:0] prog_cfg_i = 8'h00;
    logic [4:0] pad_oe_o, freq_code_o, strap_rb_n_o;
    logic       ref_drive_en_o, stop_req_en_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    strap_freq_select uut (
        .clk(clk), .rst_n(rst_n), .strap_pad_i(strap_pad_i), .prog_cfg_i(prog_cfg_i),
        .pad_oe_o(pad_oe_o), .freq_code_o(freq_code_o), .strap_rb_n_o(strap_rb_n_o),
        .ref_drive_en_o(ref_drive_en_o), .stop_req_en_o(stop_req_en_o)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // reset, release, pass the capture edge and the first driven edge
    task automatic boot(input logic [4:0] pins);
        rst_n = 1'b0;
        strap_pad_i = pins;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R3 oe low after capture edge", {3'b0, pad_oe_o}, 8'h00);
        @(negedge clk);
        chk("R3 oe high one edge later", {3'b0, pad_oe_o}, 8'h1f);
    endtask

    task automatic t_reset_state();
        rst_n = 1'b0;
        prog_cfg_i = 8'h00;
        strap_pad_i = 5'b00000;
        repeat (2) @(negedge clk);
        chk("R1 oe in reset", {3'b0, pad_oe_o}, 8'h00);
        chk("R1 roles in reset", {6'b0, ref_drive_en_o, stop_req_en_o}, 8'h00);
        chk("R1 readback in reset", {3'b0, strap_rb_n_o}, 8'h00);
        chk("R1 code in reset", {3'b0, freq_code_o}, 8'h0f);
    endtask

    task automatic t_capture(input logic [4:0] pins);
        prog_cfg_i = 8'h00;
        boot(pins);
        chk("R2 captured via readback", {3'b0, strap_rb_n_o}, {3'b0, ~pins});
        chk("R7 readback inverted", {3'b0, ~strap_rb_n_o}, {3'b0, pins});
        chk("R5 strap code", {3'b0, freq_code_o}, {4'b0, pins[3:0]});
        chk("R8 roles", {6'b0, ref_drive_en_o, stop_req_en_o},
            {6'b0, pins[4], ~pins[4]});
    endtask

    task automatic t_ignore_changes();
        prog_cfg_i = 8'h00;
        boot(5'b10110);
        strap_pad_i = 5'b01001;
        repeat (3) @(negedge clk);
        chk("R4 readback unchanged", {3'b0, strap_rb_n_o}, 8'h09);
        chk("R4 code unchanged", {3'b0, freq_code_o}, 8'h06);
        chk("R4 role unchanged", {6'b0, ref_drive_en_o, stop_req_en_o}, 8'h02);
    endtask

    task automatic t_prog_source();
        boot(5'b00011);
        prog_cfg_i = 8'b1010_1100;
        @(negedge clk);
        chk("R6 prog code hi set", {3'b0, freq_code_o}, 8'h1a);
        prog_cfg_i = 8'b0101_1000;
        @(negedge clk);
        chk("R6 prog code hi clear", {3'b0, freq_code_o}, 8'h05);
        prog_cfg_i = 8'b1111_0100;
        @(negedge clk);
        chk("R5 back to strap code", {3'b0, freq_code_o}, 8'h03);
    endtask

    task automatic t_rereset();
        prog_cfg_i = 8'h00;
        boot(5'b11111);
        rst_n = 1'b0;
        #1;
        chk("R9 oe drops in reset", {3'b0, pad_oe_o}, 8'h00);
        boot(5'b00101);
        chk("R9 fresh capture", {3'b0, strap_rb_n_o}, 8'h1a);
        chk("R9 fresh code", {3'b0, freq_code_o}, 8'h05);
    endtask

    initial begin
        t_reset_state();
        t_capture(5'b11111);
        t_capture(5'b00000);
        t_capture(5'b10101);
        t_capture(5'b01010);
        t_ignore_changes();
        t_prog_source();
        t_rereset();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule